// File: doc/BRIEF.md
# Serial Frame Address Extractor

This block watches the receive side of a 10 Mb/s style network link. Data arrives as an NRZ bit stream that is sampled on a serial clock of about 10 MHz. After the start-of-frame delimiter, the block collects the first 48-bit address (the destination) and then the second 48-bit address (the source). It passes each completed address into the faster system-clock domain, where downstream filtering logic receives it together with a one-cycle valid pulse.

A detector clocked by the system clock watches the serial clock. Parsing is blocked until that detector sees the serial clock toggling at a healthy rate. Parsing is also blocked while the active-low network-ready input is high. When network-ready goes high, the parser returns to hunting, and any address still being collected is dropped.

After both addresses of a frame have been taken, the parser ignores the rest of the frame until network-ready goes high. A bit pattern inside the payload that looks like a delimiter therefore cannot start a second capture.

Top module: `serial_addr_extract`

## Requirements
- R1: While reset is held, `clkValid`, `dstValid` and `srcValid` are 0, and `dstAddr` and `srcAddr` are all zeros.
- R2: `clkValid` goes to 1 once two serial-clock edges (rising or falling) are seen no more than 8 system clocks apart. With a 10 MHz serial clock and a 100 MHz system clock, this happens within 30 system clocks of the serial clock starting.
- R3: `clkValid` goes to 0 after 16 system clocks with no serial-clock edge. It stays 0 if the edges are more than 8 system clocks apart. While `clkValid` is 0, no frame produces a valid pulse.
- R4: Capture begins only after the delimiter, which is the serial bits 1,0,1,0,1,0,1,1 in arrival order. An alternating 1,0 preamble of any length, including none, comes before it. A frame whose delimiter is corrupted produces no pulse.
- R5: The 48 bits after the delimiter form `dstAddr`. The first byte received lands in bits 47:40 and the last byte in bits 7:0. Within each byte, the first bit received is the least significant bit.
- R6: The next 48 bits form `srcAddr`, using the same byte and bit order. Its valid pulse comes later than the destination pulse and never in the same cycle.
- R7: `dstValid` and `srcValid` are each high for exactly one system clock per delivered address. Each address output changes only in the cycle its valid pulse is high.
- R8: If `netRdyN` goes high before an address is complete, that address is discarded: no pulse is produced and its output keeps its previous value. An address that completed earlier in the same frame is still delivered. The next frame is parsed normally.
- R9: While `netRdyN` is high, serial data is not parsed, even if it contains a delimiter and addresses.
- R10: After the source address, the remaining bits of the frame are ignored until `netRdyN` goes high. A delimiter followed by more addresses in the payload produces no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock; also samples the serial clock for presence detection |
| rstN | input | 1 | Asynchronous active-low reset for both clock domains |
| serClk | input | 1 | Serial receive clock, nominally 10 MHz |
| serData | input | 1 | NRZ serial data, sampled on the rising edge of serClk |
| netRdyN | input | 1 | Active-low enable for parsing, synchronous to serClk |
| clkValid | output | 1 | Serial clock is judged present (system domain) |
| dstAddr | output | 48 | Last delivered destination address |
| dstValid | output | 1 | One-cycle strobe: new dstAddr |
| srcAddr | output | 48 | Last delivered source address |
| srcValid | output | 1 | One-cycle strobe: new srcAddr |

## Verification
The assertions assume that the serial clock is much slower than the system clock. Its edges must be several system clocks apart, so that a toggle crosses the synchronizer long before the held address changes again. They also assume that `netRdyN` and `serData` change only away from the rising edge of the serial clock. The stimulus keeps to these assumptions: it runs a 10 MHz or slower serial clock against the 100 MHz system clock, and it changes data and network-ready only on the falling edge of the serial clock.

// File: rtl/addr_extract_pkg.sv
package addr_extract_pkg;

  // Strobes from the serial-side control to the serial-side datapath
  typedef struct packed {
    logic huntShift;  // push serData into delimiter window
    logic huntClear;  // empty delimiter window
    logic capDst;     // store serData into destination shadow
    logic capSrc;     // store serData into source shadow
    logic pubDst;     // destination complete: copy to hold, flip toggle
    logic pubSrc;     // source complete: copy to hold, flip toggle
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    PS_HUNT = 2'd0,
    PS_DST  = 2'd1,
    PS_SRC  = 2'd2,
    PS_HOLD = 2'd3
  } parseState_t;

endpackage

// File: rtl/addr_sync_bit.sv
module addr_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/addr_clk_monitor.sv
module addr_clk_monitor #(
  parameter int WIN         = 8,
  parameter int LOSS        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic sysClk,
  input  logic rstN,
  input  logic serClk,
  output logic clkValid
);
  localparam int GAP_W = $clog2(LOSS + 1);

  logic             serSync;
  logic             serPrev;
  logic             edgeSeen;
  logic [GAP_W-1:0] gapCnt;

  addr_sync_bit #(.STAGES(SYNC_STAGES)) u_serSync (
    .clk (sysClk),
    .rstN(rstN),
    .din (serClk),
    .dout(serSync)
  );

  assign edgeSeen = serSync ^ serPrev;

  // gapCnt = system clocks since the last edge, saturating at LOSS.
  // It starts saturated, so a single edge after reset is not enough.
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      serPrev  <= 1'b0;
      gapCnt   <= GAP_W'(LOSS);
      clkValid <= 1'b0;
    end else begin
      serPrev <= serSync;
      if (edgeSeen) begin
        if (gapCnt < GAP_W'(WIN)) clkValid <= 1'b1;
        gapCnt <= '0;
      end else begin
        if (gapCnt != GAP_W'(LOSS)) gapCnt <= gapCnt + 1'b1;
        if (gapCnt == GAP_W'(LOSS - 1)) clkValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/addr_parse_ctrl.sv
module addr_parse_ctrl
  import addr_extract_pkg::*;
#(
  parameter int ADDR_BITS = 48,
  localparam int IDX_W    = $clog2(ADDR_BITS)
) (
  input  logic             serClk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             sfdHit,
  output ctrlStrobes_t     strobe,
  output logic [IDX_W-1:0] bitIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BITS - 1);

  parseState_t state;
  logic        lastBit;

  assign lastBit = (bitIdx == LAST_IDX);

  always_comb begin
    strobe = '0;
    if (!runEn) begin
      strobe.huntClear = 1'b1;
    end else begin
      unique case (state)
        PS_HUNT: strobe.huntShift = 1'b1;
        PS_DST: begin
          strobe.capDst = 1'b1;
          strobe.pubDst = lastBit;
        end
        PS_SRC: begin
          strobe.capSrc = 1'b1;
          strobe.pubSrc = lastBit;
        end
        PS_HOLD: strobe.huntClear = 1'b1;
        default: strobe = '0;
      endcase
    end
  end

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      state  <= PS_HUNT;
      bitIdx <= '0;
    end else if (!runEn) begin
      state  <= PS_HUNT;
      bitIdx <= '0;
    end else begin
      unique case (state)
        PS_HUNT: begin
          bitIdx <= '0;
          if (sfdHit) state <= PS_DST;
        end
        PS_DST: begin
          if (lastBit) begin
            state  <= PS_SRC;
            bitIdx <= '0;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
        PS_SRC: begin
          if (lastBit) begin
            state  <= PS_HOLD;
            bitIdx <= '0;
          end else begin
            bitIdx <= bitIdx + 1'b1;
          end
        end
        PS_HOLD: state <= PS_HOLD;
        default: state <= PS_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/addr_parse_dp.sv
module addr_parse_dp
  import addr_extract_pkg::*;
#(
  parameter int         ADDR_BITS = 48,
  parameter logic [7:0] SFD_PAT   = 8'hAB,
  localparam int        IDX_W     = $clog2(ADDR_BITS)
) (
  input  logic                 serClk,
  input  logic                 rstN,
  input  logic                 serData,
  input  ctrlStrobes_t         strobe,
  input  logic [IDX_W-1:0]     bitIdx,
  output logic                 sfdHit,
  output logic [ADDR_BITS-1:0] dstHold,
  output logic [ADDR_BITS-1:0] srcHold,
  output logic                 dstTog,
  output logic                 srcTog
);
  localparam int BYTES = ADDR_BITS / 8;

  logic [6:0]           huntWin;
  logic [IDX_W-1:0]     wrPos;
  logic [ADDR_BITS-1:0] dstShadow, srcShadow;
  logic [ADDR_BITS-1:0] dstNext, srcNext;

  // newest bit sits at the LSB, so arrival order reads MSB to LSB
  assign sfdHit = ({huntWin, serData} == SFD_PAT);

  // first byte lands in the top byte, each byte arrives LSB first
  always_comb begin
    wrPos = IDX_W'((BYTES - 1 - int'(bitIdx[IDX_W-1:3])) * 8 + int'(bitIdx[2:0]));
    dstNext = dstShadow;
    dstNext[wrPos] = serData;
    srcNext = srcShadow;
    srcNext[wrPos] = serData;
  end

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      huntWin <= '0;
    end else if (strobe.huntClear) begin
      huntWin <= '0;
    end else if (strobe.huntShift) begin
      huntWin <= {huntWin[5:0], serData};
    end
  end

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      dstShadow <= '0;
      srcShadow <= '0;
      dstHold   <= '0;
      srcHold   <= '0;
      dstTog    <= 1'b0;
      srcTog    <= 1'b0;
    end else begin
      if (strobe.capDst) dstShadow <= dstNext;
      if (strobe.capSrc) srcShadow <= srcNext;
      if (strobe.pubDst) begin
        dstHold <= dstNext;
        dstTog  <= ~dstTog;
      end
      if (strobe.pubSrc) begin
        srcHold <= srcNext;
        srcTog  <= ~srcTog;
      end
    end
  end
endmodule

// File: rtl/addr_cdc_deliver.sv
module addr_cdc_deliver #(
  parameter int WIDTH       = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic             sysClk,
  input  logic             rstN,
  input  logic             togIn,
  input  logic [WIDTH-1:0] holdIn,
  output logic [WIDTH-1:0] addrOut,
  output logic             validOut
);
  logic togSync;
  logic togPrev;

  addr_sync_bit #(.STAGES(SYNC_STAGES)) u_togSync (
    .clk (sysClk),
    .rstN(rstN),
    .din (togIn),
    .dout(togSync)
  );

  // holdIn is quiet for many system clocks around each toggle flip
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      togPrev  <= 1'b0;
      addrOut  <= '0;
      validOut <= 1'b0;
    end else begin
      togPrev  <= togSync;
      validOut <= togSync ^ togPrev;
      if (togSync ^ togPrev) addrOut <= holdIn;
    end
  end
endmodule

// File: rtl/serial_addr_extract.sv
module serial_addr_extract
  import addr_extract_pkg::*;
#(
  parameter int         ADDR_BITS   = 48,
  parameter logic [7:0] SFD_PAT     = 8'hAB,
  parameter int         CLK_WIN     = 8,
  parameter int         CLK_LOSS    = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 sysClk,
  input  logic                 rstN,
  input  logic                 serClk,
  input  logic                 serData,
  input  logic                 netRdyN,
  output logic                 clkValid,
  output logic [ADDR_BITS-1:0] dstAddr,
  output logic                 dstValid,
  output logic [ADDR_BITS-1:0] srcAddr,
  output logic                 srcValid
);
  localparam int IDX_W = $clog2(ADDR_BITS);

  logic                 clkValidSer;
  logic                 runEn;
  logic                 sfdHit;
  ctrlStrobes_t         strobe;
  logic [IDX_W-1:0]     bitIdx;
  logic [ADDR_BITS-1:0] dstHold, srcHold;
  logic                 dstTog, srcTog;

  addr_clk_monitor #(
    .WIN(CLK_WIN), .LOSS(CLK_LOSS), .SYNC_STAGES(SYNC_STAGES)
  ) u_clkMon (
    .sysClk  (sysClk),
    .rstN    (rstN),
    .serClk  (serClk),
    .clkValid(clkValid)
  );

  addr_sync_bit #(.STAGES(SYNC_STAGES)) u_validToSer (
    .clk (serClk),
    .rstN(rstN),
    .din (clkValid),
    .dout(clkValidSer)
  );

  assign runEn = clkValidSer & ~netRdyN;

  addr_parse_ctrl #(.ADDR_BITS(ADDR_BITS)) u_ctrl (
    .serClk(serClk),
    .rstN  (rstN),
    .runEn (runEn),
    .sfdHit(sfdHit),
    .strobe(strobe),
    .bitIdx(bitIdx)
  );

  addr_parse_dp #(.ADDR_BITS(ADDR_BITS), .SFD_PAT(SFD_PAT)) u_dp (
    .serClk (serClk),
    .rstN   (rstN),
    .serData(serData),
    .strobe (strobe),
    .bitIdx (bitIdx),
    .sfdHit (sfdHit),
    .dstHold(dstHold),
    .srcHold(srcHold),
    .dstTog (dstTog),
    .srcTog (srcTog)
  );

  addr_cdc_deliver #(.WIDTH(ADDR_BITS), .SYNC_STAGES(SYNC_STAGES)) u_dstXfer (
    .sysClk  (sysClk),
    .rstN    (rstN),
    .togIn   (dstTog),
    .holdIn  (dstHold),
    .addrOut (dstAddr),
    .validOut(dstValid)
  );

  addr_cdc_deliver #(.WIDTH(ADDR_BITS), .SYNC_STAGES(SYNC_STAGES)) u_srcXfer (
    .sysClk  (sysClk),
    .rstN    (rstN),
    .togIn   (srcTog),
    .holdIn  (srcHold),
    .addrOut (srcAddr),
    .validOut(srcValid)
  );
endmodule

// File: rtl/addr_extract_checker.sv
module addr_extract_checker #(
  parameter int ADDR_BITS = 48
) (
  input logic                 sysClk,
  input logic                 rstN,
  input logic                 clkValid,
  input logic [ADDR_BITS-1:0] dstAddr,
  input logic                 dstValid,
  input logic [ADDR_BITS-1:0] srcAddr,
  input logic                 srcValid
);
  // R7: strobes last one system clock
  a_r7_dst_single_pulse: assert property (@(posedge sysClk) disable iff (!rstN)
    dstValid |=> !dstValid);
  a_r7_src_single_pulse: assert property (@(posedge sysClk) disable iff (!rstN)
    srcValid |=> !srcValid);

  // R7: address outputs move only together with their strobe
  a_r7_dst_stable: assert property (@(posedge sysClk) disable iff (!rstN)
    !dstValid |=> $stable(dstAddr) || dstValid);
  a_r7_src_stable: assert property (@(posedge sysClk) disable iff (!rstN)
    !srcValid |=> $stable(srcAddr) || srcValid);

  // R6: the two strobes never coincide
  a_r6_no_overlap: assert property (@(posedge sysClk) disable iff (!rstN)
    !(dstValid && srcValid));

  // R3: no delivery while the serial clock is judged absent
  a_r3_gated: assert property (@(posedge sysClk) disable iff (!rstN)
    !clkValid |-> !dstValid && !srcValid);
endmodule

bind serial_addr_extract addr_extract_checker #(.ADDR_BITS(ADDR_BITS)) u_addrChk (
  .sysClk  (sysClk),
  .rstN    (rstN),
  .clkValid(clkValid),
  .dstAddr (dstAddr),
  .dstValid(dstValid),
  .srcAddr (srcAddr),
  .srcValid(srcValid)
);

// File: tb/test_serial_addr_extract.sv
module test_serial_addr_extract;
  localparam logic [7:0] SFD = 8'hAB;

  logic        sysClk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic        netRdyN = 1'b1;
  logic        clkValid, dstValid, srcValid;
  logic [47:0] dstAddr, srcAddr;

  int  serHalf = 50;
  bit  serRun = 1'b0;
  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  int          dstCount = 0, srcCount = 0;
  logic [47:0] lastDst = '0, lastSrc = '0;
  logic [47:0] prevDst = '0, prevSrc = '0;
  logic        prevDstV = 1'b0, prevSrcV = 1'b0;
  int          longPulse = 0, strayChange = 0;

  serial_addr_extract i_serial_addr_extract (
    .sysClk(sysClk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .netRdyN(netRdyN), .clkValid(clkValid), .dstAddr(dstAddr),
    .dstValid(dstValid), .srcAddr(srcAddr), .srcValid(srcValid)
  );

  always #5ns sysClk = ~sysClk;

  always begin
    if (serRun) begin
      #(serHalf * 1ns);
      serClk = ~serClk;
    end else begin
      #10ns;
    end
  end

  // observe outputs away from the active edge
  always @(negedge sysClk) begin
    if (rstN) begin
      if (dstValid) begin dstCount++; lastDst = dstAddr; end
      if (srcValid) begin srcCount++; lastSrc = srcAddr; end
      if (dstValid && prevDstV) longPulse++;
      if (srcValid && prevSrcV) longPulse++;
      if (dstAddr != prevDst && !dstValid) strayChange++;
      if (srcAddr != prevSrc && !srcValid) strayChange++;
    end
    prevDstV = dstValid; prevSrcV = srcValid;
    prevDst = dstAddr; prevSrc = srcAddr;
  end

  // vector: {destination, source, preamble length}
  localparam int NVEC = 4;
  localparam logic [103:0] VEC [NVEC] = '{
    {48'h0123_4567_89AB, 48'hFEDC_BA98_7654, 8'd16},
    {48'hFFFF_FFFF_FFFF, 48'h0000_0000_0001, 8'd4},
    {48'h8000_0000_0000, 48'h0100_0000_0080, 8'd0},
    {48'hA5A5_5A5A_C33C, 48'h1234_5678_9ABC, 8'd56}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge serClk);
    serData = b;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendBit(v[i]);
  endtask

  task automatic sendAddr(input logic [47:0] a);
    for (int k = 5; k >= 0; k--) sendByte(a[k*8 +: 8]);
  endtask

  task automatic sendLead(input int pre, input logic [7:0] delim);
    for (int i = 0; i < pre; i++) sendBit(i % 2 == 0);
    for (int i = 7; i >= 0; i--) sendBit(delim[i]);
  endtask

  task automatic openFrame();
    @(negedge serClk);
    netRdyN = 1'b0;
  endtask

  task automatic closeFrame();
    @(negedge serClk);
    netRdyN = 1'b1;
    serData = 1'b0;
    repeat (10) @(posedge serClk);
  endtask

  task automatic fullFrame(input logic [47:0] da, input logic [47:0] sa, input int pre);
    openFrame();
    sendLead(pre, SFD);
    sendAddr(da);
    sendAddr(sa);
    for (int i = 0; i < 12; i++) sendBit(i[0]);
    closeFrame();
  endtask

  initial begin
    #1ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int d0, s0;
    // R1: reset state
    repeat (5) @(negedge sysClk);
    chk("R1 clkValid", 64'(clkValid), 64'd0);
    chk("R1 valids", 64'({dstValid, srcValid}), 64'd0);
    chk("R1 dstAddr", 64'(dstAddr), 64'd0);
    chk("R1 srcAddr", 64'(srcAddr), 64'd0);
    rstN = 1'b1;

    // R3: too slow a serial clock is never declared valid, frames ignored
    serHalf = 200;
    serRun = 1'b1;
    repeat (100) @(negedge sysClk);
    chk("R3 slow clock invalid", 64'(clkValid), 64'd0);
    fullFrame(48'h1111_2222_3333, 48'h4444_5555_6666, 16);
    chk("R3 no dst while invalid", 64'(dstCount), 64'd0);
    chk("R3 no src while invalid", 64'(srcCount), 64'd0);

    // R2: 10 MHz serial clock becomes valid quickly
    serRun = 1'b0;
    #200ns;
    serHalf = 50;
    serRun = 1'b1;
    repeat (30) @(negedge sysClk);
    chk("R2 clkValid", 64'(clkValid), 64'd1);
    repeat (4) @(posedge serClk);

    // R5 / R6: table of frames
    for (int v = 0; v < NVEC; v++) begin
      d0 = dstCount; s0 = srcCount;
      fullFrame(VEC[v][103:56], VEC[v][55:8], int'(VEC[v][7:0]));
      chk("R5 dst count", 64'(dstCount - d0), 64'd1);
      chk("R5 dst value", 64'(lastDst), 64'(VEC[v][103:56]));
      chk("R6 src count", 64'(srcCount - s0), 64'd1);
      chk("R6 src value", 64'(lastSrc), 64'(VEC[v][55:8]));
    end

    // R4: corrupted delimiter, all-zero addresses cannot fake one
    d0 = dstCount; s0 = srcCount;
    openFrame();
    sendLead(16, 8'hA9);
    sendAddr('0);
    sendAddr('0);
    closeFrame();
    chk("R4 bad delimiter dst", 64'(dstCount - d0), 64'd0);
    chk("R4 bad delimiter src", 64'(srcCount - s0), 64'd0);

    // R8: abort inside destination
    d0 = dstCount; s0 = srcCount;
    openFrame();
    sendLead(8, SFD);
    for (int i = 0; i < 30; i++) sendBit(1'b1);
    closeFrame();
    chk("R8 partial dst dropped", 64'(dstCount - d0), 64'd0);
    chk("R8 dst held", 64'(dstAddr), 64'(VEC[NVEC-1][103:56]));

    // R8: abort inside source, destination still delivered
    d0 = dstCount; s0 = srcCount;
    openFrame();
    sendLead(8, SFD);
    sendAddr(48'hC0FF_EE00_1234);
    for (int i = 0; i < 20; i++) sendBit(1'b1);
    closeFrame();
    chk("R8 complete dst kept", 64'(lastDst), 64'h0000_C0FF_EE00_1234);
    chk("R8 partial src dropped", 64'(srcCount - s0), 64'd0);
    chk("R8 src held", 64'(srcAddr), 64'(VEC[NVEC-1][55:8]));
    fullFrame(48'h0A0B_0C0D_0E0F, 48'h1020_3040_5060, 8);
    chk("R8 recovery dst", 64'(lastDst), 64'h0000_0A0B_0C0D_0E0F);
    chk("R8 recovery src", 64'(lastSrc), 64'h0000_1020_3040_5060);

    // R9: network-ready high blocks parsing
    d0 = dstCount; s0 = srcCount;
    sendLead(8, SFD);
    sendAddr(48'h7777_7777_7777);
    sendAddr(48'h8888_8888_8888);
    repeat (10) @(posedge serClk);
    chk("R9 no dst", 64'(dstCount - d0), 64'd0);
    chk("R9 no src", 64'(srcCount - s0), 64'd0);

    // R10: delimiter in payload is ignored
    d0 = dstCount; s0 = srcCount;
    openFrame();
    sendLead(16, SFD);
    sendAddr(48'h0102_0304_0506);
    sendAddr(48'h0708_090A_0B0C);
    sendLead(8, SFD);
    sendAddr(48'hDEAD_BEEF_0001);
    sendAddr(48'hDEAD_BEEF_0002);
    closeFrame();
    chk("R10 one dst", 64'(dstCount - d0), 64'd1);
    chk("R10 dst value", 64'(lastDst), 64'h0000_0102_0304_0506);
    chk("R10 one src", 64'(srcCount - s0), 64'd1);
    chk("R10 src value", 64'(lastSrc), 64'h0000_0708_090A_0B0C);

    // R7: strobe width and output stability over the whole run
    chk("R7 pulse width", 64'(longPulse), 64'd0);
    chk("R7 stray change", 64'(strayChange), 64'd0);

    // R3: loss of serial clock
    serRun = 1'b0;
    repeat (10) @(negedge sysClk);
    chk("R3 still valid early", 64'(clkValid), 64'd1);
    repeat (20) @(negedge sysClk);
    chk("R3 invalid after loss", 64'(clkValid), 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule